// File: doc/BRIEF.md
# Dual-Role Synchronous Serial Port

This block is a byte-wide SPI port that a host configures through a small register interface. One configuration bit selects the role. As master, the port makes the serial clock from the system clock, drives data out on MOSI and takes data in from MISO. As slave, it follows an external serial clock, takes data from MOSI and returns data on MISO. MISO is driven only while the slave is selected.

Clock polarity and clock phase can each be selected, which gives four timing formats. Both roles use the same timing rules. While it is master, the port expects its select input to stay high. If that input goes low, the port records a sticky bus error, stops the transfer in progress and releases its clock and data outputs until software clears the error.

Register map, selected by `reg_addr`:
- 0 is control: bit 0 role (1 = master), bit 1 clock polarity, bit 2 clock phase, bits 4:3 rate code.
- 1 is data: a write stores the transmit byte and, in master mode, starts a transfer. A read returns the last received byte.
- 2 is status: bit 0 done, bit 1 bus error, bit 2 busy.

Register reads are combinational from `reg_addr`. `reg_rd` only marks the read side effect.

Top module: `spi_port`

## Requirements
- R1: In master mode the port shifts the byte written to register 1 out on `mosi_o`, most significant bit first. At the same time it assembles the byte seen on `miso_i`, and that byte is then read back from register 1. `sck_oe` and `mosi_oe` are 1 in master mode while no bus error is pending.
- R2: While no transfer is running, `sck_o` rests at the level of control bit 1 (0 = low idle, 1 = high idle).
- R3: With control bit 2 = 0, data is sampled on the leading clock edge (idle to active) and changed on the trailing edge. With bit 2 = 1, data is changed on the leading edge and sampled on the trailing edge. This holds in both roles.
- R4: Rate code r (control bits 4:3) divides the system clock by 2^(r+1). Each SCK half period lasts 2^r system cycles, so status bit 2 (busy) stays set for exactly 16·2^r cycles after the data write.
- R5: In slave mode the port assembles the byte clocked in on `mosi_i` by `sck_i`, and sends on `miso_o` the byte last written to register 1, most significant bit first. `sck_oe` and `mosi_oe` are 0.
- R6: `miso_oe` is 1 only in slave mode while the select input is low. The select input passes through a two-flop synchronizer, so `miso_oe` follows a change of `ss_n_i` on the second rising clock edge after it.
- R7: In master mode, a low level on `ss_n_i` sets status bit 1 (bus error) within three clock cycles. The error clears busy, ends the transfer and forces `sck_oe` and `mosi_oe` to 0.
- R8: The bus-error bit stays set until a write to register 2 with bit 1 = 1. A write with bit 1 = 0 leaves it set. While it is set, a write to register 1 starts no transfer.
- R9: Status bit 0 (done) is set when the eighth bit of a byte completes. It is cleared by a read of register 1 (`reg_rd` with address 1).
- R10: After reset, control and status read 0, `sck_oe`, `mosi_oe` and `miso_oe` are 0, and the port is a slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| sck_i | input | 1 | Serial clock input (slave role) |
| sck_o | output | 1 | Serial clock output (master role) |
| sck_oe | output | 1 | Enable for `sck_o` |
| mosi_i | input | 1 | Serial data in (slave role) |
| mosi_o | output | 1 | Serial data out (master role) |
| mosi_oe | output | 1 | Enable for `mosi_o` |
| miso_i | input | 1 | Serial data in (master role) |
| miso_o | output | 1 | Serial data out (slave role) |
| miso_oe | output | 1 | Enable for `miso_o` |
| ss_n_i | input | 1 | Active-low select input |

## Verification
The master role is swept over all four polarity and phase formats, all four rate codes and two data patterns, with a modelled slave on the wire. The busy-cycle count separates the divide ratios. The bytes captured by the model and the byte read back separate the sampling and changing edges, and catch errors in bit order. The slave role is driven by a modelled master in all four formats with complementary patterns. This shows that the data directions are swapped and that the output enable follows the synchronized select with the specified latency. A select pulse during a master transfer checks the abort, the output release, the stickiness of the error bit, and the start being ignored while the error is set, followed by the clear-by-one behaviour.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int BYTE_W = 8;
    localparam int RATE_W = 2;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_DATA = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              cpha;
        logic              cpol;
        logic              master;
    } ctrl_t;

    typedef struct packed {
        logic busy;
        logic bus_err;
        logic done;
    } status_t;

    function automatic logic edge_leading(input logic prev, input logic cur, input logic pol);
        return (prev == pol) && (cur != pol);
    endfunction

    function automatic logic edge_trailing(input logic prev, input logic cur, input logic pol);
        return (prev != pol) && (cur == pol);
    endfunction

endpackage

// File: rtl/spi_clk_gen.sv
module spi_clk_gen
    import spi_port_pkg::*;
#(
    parameter int RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          cpol,
    input  logic [RW-1:0] rate,
    output logic          sck,
    output logic          lead,
    output logic          trail
);
    localparam int HALF_W = (1 << RW) - 1;

    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] lim;
    logic              tick;

    always_comb begin
        lim   = HALF_W'((32'd1 << rate) - 32'd1);
        tick  = run && (cnt == lim);
        lead  = tick && (sck == cpol);
        trail = tick && (sck != cpol);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            sck <= cpol;
        end else if (tick) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              cpha,
    input  logic              lead,
    input  logic              trail,
    input  logic              din,
    output logic              dout,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] rx_next;
    logic [CNT_W-1:0]  bit_cnt;
    logic              take;
    logic              shift;

    always_comb begin
        rx_next = {rx_sh[DATA_W-2:0], din};
        take    = cpha ? trail : lead;
        shift   = cpha ? (lead && (bit_cnt != '0)) : trail;
        done    = !clear && trail && (bit_cnt == LAST);
        dout    = tx_sh[DATA_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            bit_cnt <= '0;
            rx_byte <= '0;
        end else begin
            if (done) rx_byte <= cpha ? rx_next : rx_sh;
            if (load) begin
                tx_sh   <= load_data;
                rx_sh   <= '0;
                bit_cnt <= '0;
            end else if (clear) begin
                bit_cnt <= '0;
            end else begin
                if (take)  rx_sh <= rx_next;
                if (shift) tx_sh <= tx_sh << 1;
                if (trail) bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_n_i
);
    localparam int CTRL_W = $bits(ctrl_t);
    localparam int STAT_W = $bits(status_t);

    ctrl_t             ctrl;
    status_t           stat;
    logic [DATA_W-1:0] tx_hold;
    logic [2:0]        ss_sync;
    logic [2:0]        sck_sync;
    logic [1:0]        mosi_sync;

    logic is_master, fault, start, wr_ctrl, wr_data, wr_stat, rd_data, clr_req;
    logic m_lead, m_trail, s_lead, s_trail, s_active;
    logic eng_lead, eng_trail, eng_din, eng_clear, eng_load, eng_dout, eng_done;
    logic [DATA_W-1:0] eng_rx, eng_ld;

    always_comb begin
        is_master = ctrl.master;
        wr_ctrl   = reg_wr && (reg_sel_e'(reg_addr) == SEL_CTRL);
        wr_data   = reg_wr && (reg_sel_e'(reg_addr) == SEL_DATA);
        wr_stat   = reg_wr && (reg_sel_e'(reg_addr) == SEL_STAT);
        rd_data   = reg_rd && (reg_sel_e'(reg_addr) == SEL_DATA);
        clr_req   = wr_stat && reg_wdata[1];
        fault     = is_master && !ss_sync[1];
        start     = is_master && wr_data && !stat.busy && !stat.bus_err;
        s_active  = !is_master && !ss_sync[1];
        s_lead    = s_active && edge_leading(sck_sync[2], sck_sync[1], ctrl.cpol);
        s_trail   = s_active && edge_trailing(sck_sync[2], sck_sync[1], ctrl.cpol);
        eng_lead  = is_master ? m_lead  : s_lead;
        eng_trail = is_master ? m_trail : s_trail;
        eng_din   = is_master ? miso_i  : mosi_sync[1];
        eng_clear = is_master ? (!stat.busy || fault) : ss_sync[1];
        eng_load  = is_master ? start
                              : ((ss_sync[2] && !ss_sync[1]) || (s_active && eng_done));
        eng_ld    = is_master ? reg_wdata : tx_hold;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ss_sync   <= '1;
            sck_sync  <= '0;
            mosi_sync <= '0;
        end else begin
            ss_sync   <= {ss_sync[1:0], ss_n_i};
            sck_sync  <= {sck_sync[1:0], sck_i};
            mosi_sync <= {mosi_sync[0], mosi_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            stat    <= '0;
            tx_hold <= '0;
        end else begin
            if (wr_ctrl) ctrl    <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (wr_data) tx_hold <= reg_wdata;

            if (fault || !is_master)           stat.busy <= 1'b0;
            else if (start)                    stat.busy <= 1'b1;
            else if (eng_done)                 stat.busy <= 1'b0;

            if (fault)                         stat.bus_err <= 1'b1;
            else if (clr_req)                  stat.bus_err <= 1'b0;

            if (eng_done)                      stat.done <= 1'b1;
            else if (rd_data)                  stat.done <= 1'b0;
        end
    end

    spi_clk_gen #(.RW(RATE_W)) u_clk_gen (
        .clk   (clk),
        .rst   (rst),
        .run   (stat.busy),
        .cpol  (ctrl.cpol),
        .rate  (ctrl.rate),
        .sck   (sck_o),
        .lead  (m_lead),
        .trail (m_trail)
    );

    spi_shift_engine #(.DATA_W(DATA_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .clear     (eng_clear),
        .load      (eng_load),
        .load_data (eng_ld),
        .cpha      (ctrl.cpha),
        .lead      (eng_lead),
        .trail     (eng_trail),
        .din       (eng_din),
        .dout      (eng_dout),
        .done      (eng_done),
        .rx_byte   (eng_rx)
    );

    always_comb begin
        sck_oe  = is_master && !stat.bus_err;
        mosi_oe = is_master && !stat.bus_err;
        mosi_o  = is_master && eng_dout;
        miso_o  = !is_master && eng_dout;
        miso_oe = s_active;
        case (reg_sel_e'(reg_addr))
            SEL_CTRL: reg_rdata = DATA_W'(ctrl);
            SEL_DATA: reg_rdata = eng_rx;
            SEL_STAT: reg_rdata = DATA_W'({stat});
            default:  reg_rdata = '0;
        endcase
    end

    logic unused_w;
    assign unused_w = (STAT_W == 0);
endmodule

// File: rtl/spi_port_checker.sv
module spi_port_checker (
    input logic clk,
    input logic rst,
    input logic is_master,
    input logic ss_n_i,
    input logic sck_oe,
    input logic mosi_oe,
    input logic miso_oe,
    input logic bus_err,
    input logic done_flag,
    input logic eng_done,
    input logic clr_req,
    input logic rd_data
);
    // R8: error bit holds unless cleared by a one
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (bus_err && !clr_req) |=> bus_err);

    // R7: select low while master raises the error
    a_r7_fault_sets: assert property (@(posedge clk) disable iff (rst)
        (is_master && !$past(ss_n_i, 2) && !$past(rst, 1) && !$past(rst, 2)) |=> bus_err);

    // R7: outputs released while the error is set
    a_r7_outputs_off: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (!sck_oe && !mosi_oe));

    // R6: no MISO drive in master role or without select
    a_r6_miso_hiz: assert property (@(posedge clk) disable iff (rst)
        (is_master || $past(ss_n_i, 2)) |-> !miso_oe);

    // R9: completion sets the done flag
    a_r9_done_set: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> done_flag);

    // R9: a data read clears the done flag
    a_r9_done_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !eng_done) |=> !done_flag);
endmodule

bind spi_port spi_port_checker u_checker (
    .clk       (clk),
    .rst       (rst),
    .is_master (is_master),
    .ss_n_i    (ss_n_i),
    .sck_oe    (sck_oe),
    .mosi_oe   (mosi_oe),
    .miso_oe   (miso_oe),
    .bus_err   (stat.bus_err),
    .done_flag (stat.done),
    .eng_done  (eng_done),
    .clr_req   (clr_req),
    .rd_data   (rd_data)
);

// File: tb/spi_port_bench.sv
module spi_port_bench;
    localparam int CLK_P = 10;
    localparam int SHALF = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;
    logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    bit         bslv_on = 1'b0;
    bit         b_cpol, b_cpha;
    logic [7:0] b_sh, b_cap;

    spi_port u_spi_port (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_i(sck_i), .sck_o(sck_o),
        .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
    );

    always #(CLK_P/2) clk = ~clk;

    // modelled slave for master-role tests
    always @(sck_o) begin
        if (bslv_on) begin
            if (sck_o != b_cpol) begin
                if (!b_cpha) b_cap = {b_cap[6:0], mosi_o};
                else begin miso_i = b_sh[7]; b_sh = b_sh << 1; end
            end else begin
                if (!b_cpha) begin b_sh = b_sh << 1; miso_i = b_sh[7]; end
                else b_cap = {b_cap[6:0], mosi_o};
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_data(output logic [7:0] d);
        @(negedge clk);
        reg_addr = 2'd1; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic master_xfer(input bit pol, input bit pha, input int rate,
                               input logic [7:0] tx, input logic [7:0] sv);
        logic [7:0] v;
        int busy_n;
        wr(2'd0, 8'((rate << 3) | (int'(pha) << 2) | (int'(pol) << 1) | 1));
        wait_cyc(2);
        chk("R2 idle level", {31'd0, sck_o}, {31'd0, pol});
        chk("R1 outputs enabled", {30'd0, sck_oe, mosi_oe}, 32'd3);
        b_cpol = pol; b_cpha = pha; b_sh = sv; b_cap = 8'h00; miso_i = sv[7];
        bslv_on = 1'b1;
        wr(2'd1, tx);
        busy_n = 0;
        peek(2'd2, v);
        while (v[2] && busy_n < 1000) begin
            busy_n++;
            @(negedge clk);
            peek(2'd2, v);
        end
        bslv_on = 1'b0;
        chk("R4 busy cycles", busy_n, 16 << rate);
        chk("R9 done set", {31'd0, v[0]}, 32'd1);
        chk("R1 R3 mosi byte", {24'd0, b_cap}, {24'd0, tx});
        wait_cyc(1);
        chk("R2 idle after", {31'd0, sck_o}, {31'd0, pol});
        rd_data(v);
        chk("R1 R3 rx byte", {24'd0, v}, {24'd0, sv});
        peek(2'd2, v);
        chk("R9 done cleared", {31'd0, v[0]}, 32'd0);
    endtask

    task automatic slave_xfer(input bit pol, input bit pha, input logic [7:0] tx,
                              input logic [7:0] mv);
        logic [7:0] v, cap;
        cap = 8'h00;
        wr(2'd0, 8'((int'(pha) << 2) | (int'(pol) << 1)));
        wr(2'd1, tx);
        sck_i = pol;
        wait_cyc(3);
        chk("R6 hiz unselected", {31'd0, miso_oe}, 32'd0);
        chk("R5 master outputs off", {30'd0, sck_oe, mosi_oe}, 32'd0);
        ss_n_i = 1'b0;
        @(negedge clk);
        chk("R6 oe latency 1", {31'd0, miso_oe}, 32'd0);
        @(negedge clk);
        chk("R6 oe after sync", {31'd0, miso_oe}, 32'd1);
        wait_cyc(4);
        for (int i = 7; i >= 0; i--) begin
            if (!pha) begin
                mosi_i = mv[i];
                wait_cyc(SHALF);
                sck_i = ~pol; cap = {cap[6:0], miso_o};
                wait_cyc(SHALF);
                sck_i = pol;
            end else begin
                sck_i = ~pol; mosi_i = mv[i];
                wait_cyc(SHALF);
                sck_i = pol; cap = {cap[6:0], miso_o};
                wait_cyc(SHALF);
            end
        end
        wait_cyc(SHALF);
        chk("R5 R3 miso byte", {24'd0, cap}, {24'd0, tx});
        peek(2'd2, v);
        chk("R9 slave done", {31'd0, v[0]}, 32'd1);
        rd_data(v);
        chk("R5 R3 slave rx", {24'd0, v}, {24'd0, mv});
        ss_n_i = 1'b1;
        wait_cyc(3);
        chk("R6 hiz after deselect", {31'd0, miso_oe}, 32'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_err++; n_chk++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] v;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        // R10 reset state
        peek(2'd0, v); chk("R10 ctrl reset", {24'd0, v}, 32'd0);
        peek(2'd2, v); chk("R10 status reset", {24'd0, v}, 32'd0);
        chk("R10 enables reset", {29'd0, sck_oe, mosi_oe, miso_oe}, 32'd0);

        for (int pol = 0; pol < 2; pol++)
            for (int pha = 0; pha < 2; pha++)
                for (int r = 0; r < 4; r++) begin
                    master_xfer(pol[0], pha[0], r, 8'hA5 ^ 8'(r * 17), 8'h3C + 8'(pol * 64 + pha * 7));
                    master_xfer(pol[0], pha[0], r, 8'h81, 8'h7E);
                end

        for (int pol = 0; pol < 2; pol++)
            for (int pha = 0; pha < 2; pha++) begin
                slave_xfer(pol[0], pha[0], 8'hC3 ^ 8'(pol * 3), 8'h5A ^ 8'(pha * 9));
                slave_xfer(pol[0], pha[0], 8'h01, 8'hFE);
            end

        // R7 R8 mode fault during a master transfer
        wr(2'd0, 8'h19);
        wr(2'd1, 8'hF0);
        wait_cyc(20);
        ss_n_i = 1'b0;
        wait_cyc(3);
        peek(2'd2, v);
        chk("R7 error set", {31'd0, v[1]}, 32'd1);
        chk("R7 busy cleared", {31'd0, v[2]}, 32'd0);
        chk("R7 outputs released", {30'd0, sck_oe, mosi_oe}, 32'd0);
        ss_n_i = 1'b1;
        wait_cyc(5);
        peek(2'd2, v);
        chk("R8 error sticky", {31'd0, v[1]}, 32'd1);
        wr(2'd1, 8'h55);
        wait_cyc(2);
        peek(2'd2, v);
        chk("R8 no start while error", {31'd0, v[2]}, 32'd0);
        chk("R8 sck held", {31'd0, sck_o}, 32'd0);
        wr(2'd2, 8'h05);
        peek(2'd2, v);
        chk("R8 zero write keeps error", {31'd0, v[1]}, 32'd1);
        wr(2'd2, 8'h02);
        peek(2'd2, v);
        chk("R8 error cleared", {31'd0, v[1]}, 32'd0);
        chk("R8 outputs back", {30'd0, sck_oe, mosi_oe}, 32'd3);
        master_xfer(1'b0, 1'b0, 0, 8'h96, 8'h69);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule